// File: doc/BRIEF.md
# Serial Programming Command Slave

This block is the target end of a four-byte, SPI-style in-system programming link. A host opens a session by driving the session line active, then clocks command frames in on MOSI, most significant bit first. The block answers on MISO. It decodes a fixed set of operations: unlocking programming, chip erase, single-byte read and write, 256-byte page read and write, lock-bit read and write, and signature read. Every operation other than the unlock is refused until the unlock has been seen in the current session.

Program image storage is not part of the block. It drives a byte-wide port (address, write data, write strobe) into a synchronous RAM with one cycle of read latency, and it holds the lock-bit register itself. Each operation that alters the image or the lock bits sets a bit in a change-flag register. A task on the system side reads these flags, replays the work to a parallel-programmed part, and clears each flag through a mask. While the system side asserts its lock input, new sessions are ignored completely.

Top module: `isp_cmd_slave`

## Requirements
- R1: Frame bits are taken MSB first on each rising SCK edge. A reply bit appears on MISO after the rising edge of its bit slot and holds until the next rising edge. MISO is 0 outside reply bytes.
- R2: The frame 0xAC, 0x53, x, x unlocks programming for the rest of the session and returns 0x69 as its fourth byte.
- R3: The frame 0xAC, then a byte whose top three bits are 100, then two bytes writes 0xFF to every image address, one per clock, after the fourth byte. It also sets change flag bit 0.
- R4: Opcode 0x40 writes byte 4 to address {byte2[3:0], byte3}, and opcode 0x20 returns the byte at that address as byte 4. Bits 7:4 of byte 2 are ignored.
- R5: A completed byte write or page write sets change flag bit 1.
- R6: The frame 0xAC, then a byte whose top six bits are 111000, then two bytes sets lock bit 2, 3 or 4 for low bits 1, 2 or 3, and sets change flag bit 2. Opcode 0x24 returns the lock register as byte 4.
- R7: Opcode 0x28 returns signature 0x1E, 0x51 or 0x06 for byte2[3:0] = 0, 1 or 2 when byte 3 is zero. Otherwise it returns 0xFF.
- R8: Opcode 0x50 followed by a page byte writes the next 256 bytes to {page[3:0], 0..255}. Opcode 0x30 returns those 256 bytes in order.
- R9: Without the unlock, any other command, and any unrecognised opcode, is refused. The rest of the session is then ignored and its replies read 0. The unlock is lost when a session ends.
- R10: Dropping the session line mid-byte abandons the frame with no memory write and resets the bit count. The next session starts aligned.
- R11: A change flag stays set until the task side pulses its bit in the clear mask.
- R12: A session that begins while the lock input is high is ignored. It changes no memory, lock bit or flag, and MISO stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sess_i | input | 1 | Session line, high while a host session is open |
| sck_i | input | 1 | Serial clock from host |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial reply to host |
| lock_i | input | 1 | System-side lock; sessions starting while high are ignored |
| mem_addr_o | output | AW (12) | Image address |
| mem_wdata_o | output | 8 | Image write data |
| mem_we_o | output | 1 | Image write strobe |
| mem_rdata_i | input | 8 | Image read data, one cycle after address |
| chg_o | output | 3 | Change flags: bit 0 erase, bit 1 image write, bit 2 lock write |
| chg_clr_i | input | 3 | Per-bit clear mask for the change flags |
| lock_bits_o | output | 8 | Lock-bit register |

## Verification
The assertions assume that SCK, MOSI and the session line are slow compared with the system clock. They assume each SCK phase lasts at least several clocks, so that the two-stage synchronisers see every edge and each reply byte is loaded before the first rising edge of its slot. They also assume the host sends no image command while an erase is sweeping the memory, and that the lock input is synchronous to the system clock. The bench holds every SCK phase for eight clocks, waits longer than a full erase sweep before the next session, and changes the lock input only between sessions.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [7:0] OP_EXT  = 8'hAC;
  localparam logic [7:0] OP_RDB  = 8'h20;
  localparam logic [7:0] OP_WRB  = 8'h40;
  localparam logic [7:0] OP_RDL  = 8'h24;
  localparam logic [7:0] OP_RDS  = 8'h28;
  localparam logic [7:0] OP_RDP  = 8'h30;
  localparam logic [7:0] OP_WRP  = 8'h50;
  localparam logic [7:0] KEY_EN  = 8'h53;
  localparam logic [7:0] ACK_EN  = 8'h69;

  typedef enum logic [2:0] {ST_OP, ST_ARG, ST_PADR, ST_PDAT, ST_DEAD} st_e;
  typedef enum logic [3:0] {
    C_NONE, C_EXT, C_EN, C_ERASE, C_LOCKW,
    C_RDB, C_WRB, C_RDL, C_RDS, C_RDP, C_WRP
  } cmd_e;

  function automatic logic [7:0] sig_byte(input logic [7:0] idx);
    case (idx)
      8'd0:    sig_byte = 8'h1E;
      8'd1:    sig_byte = 8'h51;
      8'd2:    sig_byte = 8'h06;
      default: sig_byte = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/isp_shifter.sv
module isp_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic       sess_i,
  input  logic       lock_i,
  input  logic       tx_load_i,
  input  logic [7:0] tx_byte_i,
  output logic       run_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       miso_o
);
  logic [1:0] sck_sync, mosi_sync, sess_sync;
  logic       sck_d, sess_d, ign_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] rx_q, tx_q;
  logic       miso_q, done_q;

  logic sck_s, mosi_s, sess_s, sck_rise, sess_rise, run;
  assign sck_s     = sck_sync[1];
  assign mosi_s    = mosi_sync[1];
  assign sess_s    = sess_sync[1];
  assign sck_rise  = sck_s & ~sck_d;
  assign sess_rise = sess_s & ~sess_d;
  assign run       = sess_s & sess_d & ~ign_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sync  <= '0;
      mosi_sync <= '0;
      sess_sync <= '0;
      sck_d     <= 1'b0;
      sess_d    <= 1'b0;
      ign_q     <= 1'b0;
    end else begin
      sck_sync  <= {sck_sync[0], sck_i};
      mosi_sync <= {mosi_sync[0], mosi_i};
      sess_sync <= {sess_sync[0], sess_i};
      sck_d     <= sck_s;
      sess_d    <= sess_s;
      if (sess_rise) ign_q <= lock_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      miso_q    <= 1'b0;
      done_q    <= 1'b0;
    end else if (!run) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      miso_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sck_rise) begin
        rx_q      <= {rx_q[6:0], mosi_s};
        miso_q    <= tx_q[7];
        tx_q      <= {tx_q[6:0], 1'b0};
        bit_cnt_q <= bit_cnt_q + 3'd1;
        done_q    <= (bit_cnt_q == 3'd7);
      end else if (tx_load_i) begin
        tx_q <= tx_byte_i;
      end
    end
  end

  assign run_o       = run;
  assign byte_done_o = done_q;
  assign rx_byte_o   = rx_q;
  assign miso_o      = miso_q;

  // R10
  bit_cnt_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (bit_cnt_q == 3'd0));
  // R1
  miso_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !sck_rise) |=> $stable(miso_q));
endmodule

// File: rtl/isp_decoder.sv
module isp_decoder #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          byte_done_i,
  input  logic [7:0]    rx_i,
  input  logic [7:0]    mem_rdata_i,
  input  logic [7:0]    lock_bits_i,
  output logic          tx_load_o,
  output logic [7:0]    tx_byte_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic          mem_we_o,
  output logic          erase_go_o,
  output logic [7:0]    lock_set_o,
  output logic [2:0]    chg_set_o
);
  import isp_pkg::*;
  localparam int PW = AW - 8;

  st_e           st_q;
  cmd_e          cmd_q;
  logic [1:0]    idx_q;
  logic [7:0]    b2_q, b3_q, pcnt_q;
  logic [PW-1:0] page_q;
  logic          en_q, we_q, go_q, load_q;
  logic [1:0]    rd_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    wd_q, tx_q, lset_q;
  logic [2:0]    cset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_OP; cmd_q <= C_NONE; idx_q <= '0; b2_q <= '0; b3_q <= '0;
      pcnt_q <= '0; page_q <= '0; en_q <= 1'b0; we_q <= 1'b0; go_q <= 1'b0;
      load_q <= 1'b0; rd_q <= '0; addr_q <= '0; wd_q <= '0; tx_q <= '0;
      lset_q <= '0; cset_q <= '0;
    end else begin
      we_q   <= 1'b0;
      go_q   <= 1'b0;
      load_q <= 1'b0;
      lset_q <= '0;
      cset_q <= '0;
      rd_q   <= {rd_q[0], 1'b0};
      if (rd_q[1]) begin
        load_q <= 1'b1;
        tx_q   <= mem_rdata_i;
      end
      if (!run_i) begin
        st_q <= ST_OP;
        en_q <= 1'b0;
        rd_q <= '0;
      end else if (byte_done_i) begin
        case (st_q)
          ST_OP: begin
            idx_q <= 2'd1;
            st_q  <= en_q ? ST_ARG : ST_DEAD;
            case (rx_i)
              OP_EXT: begin cmd_q <= C_EXT; st_q <= ST_ARG; end
              OP_RDB: cmd_q <= C_RDB;
              OP_WRB: cmd_q <= C_WRB;
              OP_RDL: cmd_q <= C_RDL;
              OP_RDS: cmd_q <= C_RDS;
              OP_RDP: begin cmd_q <= C_RDP; st_q <= en_q ? ST_PADR : ST_DEAD; end
              OP_WRP: begin cmd_q <= C_WRP; st_q <= en_q ? ST_PADR : ST_DEAD; end
              default: st_q <= ST_DEAD;
            endcase
          end
          ST_ARG: begin
            idx_q <= idx_q + 2'd1;
            if (idx_q == 2'd1) begin
              b2_q <= rx_i;
              if (cmd_q == C_EXT) begin
                if (rx_i == KEY_EN) begin
                  cmd_q <= C_EN;
                  en_q  <= 1'b1;
                end else if (!en_q) st_q <= ST_DEAD;
                else if (rx_i[7:2] == 6'b111000) cmd_q <= C_LOCKW;
                else if (rx_i[7:5] == 3'b100)    cmd_q <= C_ERASE;
                else st_q <= ST_DEAD;
              end
            end else if (idx_q == 2'd2) begin
              b3_q <= rx_i;
              case (cmd_q)
                C_EN:  begin load_q <= 1'b1; tx_q <= ACK_EN; end
                C_RDL: begin load_q <= 1'b1; tx_q <= lock_bits_i; end
                C_RDS: begin
                  load_q <= 1'b1;
                  tx_q   <= (rx_i == 8'd0) ? sig_byte(b2_q & 8'h0F) : 8'hFF;
                end
                C_RDB: begin
                  addr_q <= {b2_q[PW-1:0], rx_i};
                  rd_q   <= {rd_q[0], 1'b1};
                end
                default: ;
              endcase
            end else begin
              st_q <= ST_OP;
              case (cmd_q)
                C_WRB: begin
                  addr_q    <= {b2_q[PW-1:0], b3_q};
                  wd_q      <= rx_i;
                  we_q      <= 1'b1;
                  cset_q[1] <= 1'b1;
                end
                C_LOCKW: begin
                  case (b2_q[1:0])
                    2'd1:    lset_q <= 8'h04;
                    2'd2:    lset_q <= 8'h08;
                    2'd3:    lset_q <= 8'h10;
                    default: lset_q <= 8'h00;
                  endcase
                  cset_q[2] <= 1'b1;
                end
                C_ERASE: begin
                  go_q      <= 1'b1;
                  cset_q[0] <= 1'b1;
                end
                default: ;
              endcase
            end
          end
          ST_PADR: begin
            page_q <= rx_i[PW-1:0];
            pcnt_q <= '0;
            st_q   <= ST_PDAT;
            if (cmd_q == C_RDP) begin
              addr_q <= {rx_i[PW-1:0], 8'h00};
              rd_q   <= {rd_q[0], 1'b1};
            end
          end
          ST_PDAT: begin
            pcnt_q <= pcnt_q + 8'd1;
            if (cmd_q == C_WRP) begin
              addr_q <= {page_q, pcnt_q};
              wd_q   <= rx_i;
              we_q   <= 1'b1;
            end else if (pcnt_q != 8'hFF) begin
              addr_q <= {page_q, pcnt_q + 8'd1};
              rd_q   <= {rd_q[0], 1'b1};
            end
            if (pcnt_q == 8'hFF) begin
              st_q <= ST_OP;
              if (cmd_q == C_WRP) cset_q[1] <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_load_o   = load_q;
  assign tx_byte_o   = tx_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wd_q;
  assign mem_we_o    = we_q;
  assign erase_go_o  = go_q;
  assign lock_set_o  = lset_q;
  assign chg_set_o   = cset_q;

  // R9
  we_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> en_q);
  // R9
  erase_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_q |-> en_q);
  // R9
  en_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !en_q);
endmodule

// File: rtl/isp_erase.sv
module isp_erase #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  output logic          busy_o,
  output logic [AW-1:0] addr_o
);
  logic          busy_q;
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '1) busy_q <= 1'b0;
    end else if (go_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = cnt_q;

  // R3
  erase_sweep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '1) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
  // R3
  erase_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !busy_q) |=> (busy_q && cnt_q == '0));
endmodule

// File: rtl/isp_state_regs.sv
module isp_state_regs #(
  parameter int NF = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] chg_set_i,
  input  logic [NF-1:0] chg_clr_i,
  input  logic [7:0]    lock_set_i,
  output logic [NF-1:0] chg_o,
  output logic [7:0]    lock_o
);
  logic [NF-1:0] chg_q;
  logic [7:0]    lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_q  <= '0;
      lock_q <= '0;
    end else begin
      chg_q  <= (chg_q & ~chg_clr_i) | chg_set_i;
      lock_q <= lock_q | lock_set_i;
    end
  end

  assign chg_o  = chg_q;
  assign lock_o = lock_q;

  // R11
  chg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(chg_q) & ~$past(chg_clr_i)) & ~chg_q) == '0));
  // R6
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(lock_q) & ~lock_q) == 8'h00));
endmodule

// File: rtl/isp_cmd_slave.sv
module isp_cmd_slave #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sess_i,
  input  logic          sck_i,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          lock_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic          mem_we_o,
  input  logic [7:0]    mem_rdata_i,
  output logic [2:0]    chg_o,
  input  logic [2:0]    chg_clr_i,
  output logic [7:0]    lock_bits_o
);
  logic          run, byte_done, tx_load, dec_we, erase_go, erase_busy;
  logic [7:0]    rx_byte, tx_byte, dec_wd, lock_set;
  logic [AW-1:0] dec_addr, erase_addr;
  logic [2:0]    chg_set;

  isp_shifter u_shift (
    .clk_i, .rst_ni, .sck_i, .mosi_i, .sess_i, .lock_i,
    .tx_load_i(tx_load), .tx_byte_i(tx_byte), .run_o(run),
    .byte_done_o(byte_done), .rx_byte_o(rx_byte), .miso_o
  );

  isp_decoder #(.AW(AW)) u_dec (
    .clk_i, .rst_ni, .run_i(run), .byte_done_i(byte_done), .rx_i(rx_byte),
    .mem_rdata_i, .lock_bits_i(lock_bits_o), .tx_load_o(tx_load),
    .tx_byte_o(tx_byte), .mem_addr_o(dec_addr), .mem_wdata_o(dec_wd),
    .mem_we_o(dec_we), .erase_go_o(erase_go), .lock_set_o(lock_set),
    .chg_set_o(chg_set)
  );

  isp_erase #(.AW(AW)) u_erase (
    .clk_i, .rst_ni, .go_i(erase_go), .busy_o(erase_busy), .addr_o(erase_addr)
  );

  isp_state_regs #(.NF(3)) u_regs (
    .clk_i, .rst_ni, .chg_set_i(chg_set), .chg_clr_i, .lock_set_i(lock_set),
    .chg_o, .lock_o(lock_bits_o)
  );

  assign mem_addr_o  = erase_busy ? erase_addr : dec_addr;
  assign mem_wdata_o = erase_busy ? 8'hFF : dec_wd;
  assign mem_we_o    = erase_busy | dec_we;

  // R12
  no_write_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !erase_busy) |=> !dec_we);
endmodule

// File: tb/isp_cmd_slave_tb.sv
module isp_cmd_slave_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sess = 1'b0, sck = 1'b0, mosi = 1'b0, lock = 1'b0;
  logic miso, mem_we;
  logic [11:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, lock_bits;
  logic [2:0] chg, chg_clr = 3'b000;
  int n_chk = 0, n_err = 0;
  logic [7:0] ram [4096];

  always #4 clk = ~clk;

  isp_cmd_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sess_i(sess), .sck_i(sck), .mosi_i(mosi),
    .miso_o(miso), .lock_i(lock), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata), .chg_o(chg), .chg_clr_i(chg_clr),
    .lock_bits_o(lock_bits)
  );

  always_ff @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (8) @(negedge clk);
      sck = 1'b1;
      repeat (6) @(negedge clk);
      rx[i] = miso;
      repeat (2) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cmd4(input logic [7:0] a, b, c, d, output logic [7:0] r);
    logic [7:0] t;
    xfer(a, t); xfer(b, t); xfer(c, t); xfer(d, r);
  endtask

  task automatic open_s;
    sess = 1'b1; repeat (8) @(negedge clk);
  endtask
  task automatic close_s;
    sess = 1'b0; repeat (8) @(negedge clk);
  endtask
  task automatic unlock;
    logic [7:0] r;
    cmd4(8'hAC, 8'h53, 8'h00, 8'h00, r);
  endtask
  task automatic rd_byte(input logic [11:0] a, output logic [7:0] r);
    cmd4(8'h20, {4'h0, a[11:8]}, a[7:0], 8'h00, r);
  endtask
  task automatic clr_flags;
    chg_clr = 3'b111; @(negedge clk); chg_clr = 3'b000; @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset miso", miso, 1'b0);
    check("R11 reset flags", chg, 3'b000);
    check("R6 reset lock", lock_bits, 8'h00);
  endtask

  task automatic t_enable;
    logic [7:0] r;
    open_s;
    cmd4(8'hAC, 8'h53, 8'h00, 8'h00, r);
    check("R2 R1 enable ack", r, 8'h69);
    close_s;
  endtask

  task automatic t_erase;
    logic [7:0] r;
    open_s; unlock;
    cmd4(8'hAC, 8'h80, 8'h00, 8'h00, r);
    close_s;
    repeat (4200) @(negedge clk);
    check("R3 erase flag", chg, 3'b001);
    open_s; unlock;
    rd_byte(12'h000, r); check("R3 erased 000", r, 8'hFF);
    rd_byte(12'hFFF, r); check("R3 erased FFF", r, 8'hFF);
    rd_byte(12'h3A5, r); check("R3 erased 3A5", r, 8'hFF);
    close_s;
    clr_flags;
  endtask

  task automatic t_bytes;
    logic [7:0] r;
    open_s; unlock;
    cmd4(8'h40, 8'hF3, 8'hA5, 8'h5C, r);
    cmd4(8'h40, 8'h03, 8'hA6, 8'h81, r);
    rd_byte(12'h3A5, r); check("R4 byte read", r, 8'h5C);
    cmd4(8'h20, 8'hA3, 8'hA6, 8'h00, r); check("R4 masked upper", r, 8'h81);
    close_s;
    check("R5 write flag", chg, 3'b010);
    chg_clr = 3'b001; @(negedge clk); chg_clr = 3'b000; @(negedge clk);
    check("R11 other bit kept", chg, 3'b010);
    chg_clr = 3'b010; @(negedge clk); chg_clr = 3'b000; @(negedge clk);
    check("R11 cleared", chg, 3'b000);
  endtask

  task automatic t_sig;
    logic [7:0] r;
    open_s; unlock;
    cmd4(8'h28, 8'h00, 8'h00, 8'h00, r); check("R7 sig0", r, 8'h1E);
    cmd4(8'h28, 8'h01, 8'h00, 8'h00, r); check("R7 sig1", r, 8'h51);
    cmd4(8'h28, 8'hF2, 8'h00, 8'h00, r); check("R7 sig2", r, 8'h06);
    cmd4(8'h28, 8'h01, 8'h07, 8'h00, r); check("R7 sig nonzero b3", r, 8'hFF);
    cmd4(8'h28, 8'h05, 8'h00, 8'h00, r); check("R7 sig bad index", r, 8'hFF);
    close_s;
  endtask

  task automatic t_lock;
    logic [7:0] r;
    open_s; unlock;
    cmd4(8'hAC, 8'hE1, 8'h00, 8'h00, r);
    cmd4(8'hAC, 8'hE3, 8'h00, 8'h00, r);
    cmd4(8'h24, 8'h00, 8'h00, 8'h00, r); check("R6 lock read", r, 8'h14);
    close_s;
    check("R6 lock port", lock_bits, 8'h14);
    check("R6 lock flag", chg, 3'b100);
    clr_flags;
  endtask

  task automatic t_page;
    logic [7:0] r;
    int bad = 0;
    open_s; unlock;
    xfer(8'h50, r); xfer(8'h05, r);
    for (int i = 0; i < 256; i++) xfer(8'(i) ^ 8'h5A, r);
    xfer(8'h30, r); xfer(8'h05, r);
    for (int i = 0; i < 256; i++) begin
      xfer(8'h00, r);
      if (r !== (8'(i) ^ 8'h5A)) bad++;
    end
    check("R8 page readback mismatches", bad, 0);
    rd_byte(12'h507, r); check("R8 page byte", r, 8'h5D);
    close_s;
    check("R5 page flag", chg, 3'b010);
    clr_flags;
  endtask

  task automatic t_gate;
    logic [7:0] r;
    open_s;
    cmd4(8'h40, 8'h01, 8'h10, 8'hAA, r);
    cmd4(8'hAC, 8'h53, 8'h00, 8'h00, r); check("R9 dead session", r, 8'h00);
    close_s;
    check("R9 no flag", chg, 3'b000);
    open_s; unlock;
    rd_byte(12'h110, r); check("R9 not written", r, 8'hFF);
    close_s;
    open_s;
    cmd4(8'h24, 8'h00, 8'h00, 8'h00, r); check("R9 enable lost", r, 8'h00);
    close_s;
  endtask

  task automatic t_abort;
    logic [7:0] r;
    open_s; unlock;
    xfer(8'h40, r);
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1; repeat (8) @(negedge clk);
      sck = 1'b1; repeat (8) @(negedge clk); sck = 1'b0;
    end
    close_s;
    open_s; unlock;
    cmd4(8'h40, 8'h01, 8'h20, 8'h77, r);
    rd_byte(12'h120, r); check("R10 realigned", r, 8'h77);
    close_s;
    clr_flags;
  endtask

  task automatic t_lockin;
    logic [7:0] r;
    lock = 1'b1;
    open_s;
    cmd4(8'hAC, 8'h53, 8'h00, 8'h00, r); check("R12 miso quiet", r, 8'h00);
    cmd4(8'h40, 8'h02, 8'h00, 8'h33, r);
    close_s;
    lock = 1'b0;
    check("R12 no flag", chg, 3'b000);
    open_s; unlock;
    rd_byte(12'h200, r); check("R12 no write", r, 8'hFF);
    close_s;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_enable;
    t_erase;
    t_bytes;
    t_sig;
    t_lock;
    t_page;
    t_gate;
    t_abort;
    t_lockin;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule